// File: doc/BRIEF.md
# Synchronous Burst Cache Data RAM

This block models the data store of a secondary cache: an array of 18-bit words that a processor or a cache controller reads and writes in four-beat bursts. All inputs except the output enable are taken on the rising clock edge. A burst begins when either address strobe is asserted. The processor strobe always opens a read. The controller strobe opens a read or a write, depending on the write enables. After the first beat, an internal two-bit counter walks the low two address bits in the processor's interleaved order. The counter steps only on edges where the advance input is asserted.

Each word is split into two 9-bit halves, and each half has its own write enable. Writes finish inside the clock edge that starts them, so no write pulse is needed. Read data appears in the cycle after the edge that captured the address. The output enable gates the pad drive asynchronously. The data bus is presented as an input bus, an output bus and a drive qualifier, which the pad ring merges into one bidirectional bus. The depth is `2**ADDR_W` words. The full cache configuration sets `ADDR_W = 16` (65,536 words). The default of 10 keeps elaboration small.

The control is a three-state machine. `ST_IDLE` means deselected. `ST_READ` means the last beat was a read. `ST_WRITE` means the last beat was a write. The transitions are:

- A strobe with the chip enable deasserted goes to `ST_IDLE`.
- A processor strobe goes to `ST_READ`.
- A controller strobe goes to `ST_WRITE` if any write enable is low, and to `ST_READ` otherwise.
- With no strobe, `ST_READ` or `ST_WRITE` continues the burst into `ST_WRITE` or `ST_READ`, chosen by the write enables.
- With no strobe, `ST_IDLE` stays where it is.

Top module: `burst_cache_sram`

## Requirements
- R1: The array stores words of 18 bits at `2**ADDR_W` addresses. A word written to an address is returned unchanged by a later read of that address.
- R2: A processor strobe (`adsp_n` low) with `ce_n` low loads `addr` and performs a read, whatever `lw_n` and `uw_n` are. The data at that address is on `dq_out`, with `dq_drive` high, during the next cycle if `oe_n` is low.
- R3: A controller strobe (`adsc_n` low, `adsp_n` high) with `ce_n` low loads `addr`. It writes `dq_in` there on the same edge if `lw_n` or `uw_n` is low, and otherwise reads.
- R4: When both strobes are low on one edge with `ce_n` low, the cycle is a read, as for the processor strobe.
- R5: Beat addresses keep the upper bits of the loaded address. Their low two bits are the loaded low bits XOR a two-bit count. The count starts at 0 and increments on each edge with no strobe, `adv_n` low and a burst active.
- R6: On an edge with no strobe and `adv_n` high, the beat address stays the same as on the previous beat.
- R7: After the fourth beat, a further advance returns the count to 0, which is the loaded address.
- R8: On a write beat, `lw_n` low writes bits 8:0 and `uw_n` low writes bits 17:9. A half whose enable is high keeps its old contents.
- R9: A strobe with `ce_n` high ends any burst. It writes nothing, and `dq_drive` is low in the following cycle.
- R10: `dq_drive` falls as soon as `oe_n` goes high, without waiting for a clock edge. It is high only in a read cycle with `oe_n` low.
- R11: After reset, and in `ST_IDLE` with no strobe, `dq_drive` is low and the write enables have no effect on the array.
- R12: Burst-continue beats (no strobe, burst active) honour the write enables: write if either is low, read otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | ADDR_W | Word address, taken on a strobe edge |
| ce_n | input | 1 | Active-low chip enable, examined on strobe edges |
| adsp_n | input | 1 | Active-low processor address strobe |
| adsc_n | input | 1 | Active-low controller address strobe |
| adv_n | input | 1 | Active-low burst advance |
| lw_n | input | 1 | Active-low write enable for bits 8:0 |
| uw_n | input | 1 | Active-low write enable for bits 17:9 |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dq_in | input | 18 | Write data from the shared bus |
| dq_out | output | 18 | Read data toward the shared bus |
| dq_drive | output | 1 | High when the pads should drive `dq_out` |

## Verification
The assertions check the control sequencing on every cycle. They cover:

- the strobe priority and the read on a processor strobe;
- the write decision on a controller strobe;
- the count stepping or holding with the advance input;
- the return to idle on a deselecting strobe or while idle;
- the output drive that follows each processor strobe.

The stored contents cannot be seen by a property. The bench's scenarios alone show the data results: interleaved beat order from each starting offset 0–3, wrap-around, half-word writes, and writes that must be ignored on processor strobes, deselects and idle cycles. A scenario also shows the asynchronous release of the drive in mid-cycle.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    // Access kind of the beat currently presented to the pads
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_state_t;

    localparam int HALF_W     = 9;
    localparam int NUM_HALVES = 2;
    localparam int WORD_W     = HALF_W * NUM_HALVES;
    localparam int BURST_LEN  = 4;
    localparam int CNT_W      = $clog2(BURST_LEN);

endpackage

// File: rtl/sbsram_burst_ctrl.sv
module sbsram_burst_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  ce_n,
    input  logic                  adsp_n,
    input  logic                  adsc_n,
    input  logic                  adv_n,
    input  logic                  lw_n,
    input  logic                  uw_n,
    output logic [ADDR_W-1:0]     acc_addr,
    output logic [NUM_HALVES-1:0] wr_en,
    output logic                  rd_en,
    output burst_state_t          state_q
);

    burst_state_t            state_d;
    logic [ADDR_W-1:0]       base_q, base_d;
    logic [CNT_W-1:0]        cnt_q, cnt_d;
    logic                    strobe;
    logic                    we_any;

    assign strobe = !adsp_n || !adsc_n;
    assign we_any = !lw_n || !uw_n;

    // Next-state and burst address decision
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        if (strobe) begin
            if (ce_n) begin
                state_d = ST_IDLE;
            end else begin
                base_d  = addr;
                cnt_d   = '0;
                // processor strobe wins and always reads
                state_d = (adsp_n && we_any) ? ST_WRITE : ST_READ;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_READ, ST_WRITE: begin
                    if (!adv_n) cnt_d = cnt_q + CNT_W'(1);
                    state_d = we_any ? ST_WRITE : ST_READ;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs toward the array for this edge
    always_comb begin
        acc_addr      = base_d;
        acc_addr[1:0] = base_d[1:0] ^ cnt_d;
        wr_en[0]      = (state_d == ST_WRITE) && !lw_n;
        wr_en[1]      = (state_d == ST_WRITE) && !uw_n;
        rd_en         = (state_d == ST_READ);
    end

    // R2 / R4: processor strobe opens a read burst at the given address
    a_r2_adsp_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n) |=> (state_q == ST_READ && cnt_q == '0 && base_q == $past(addr)));

    // R3: controller strobe with a write enable low opens a write
    a_r3_adsc_write: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && !adsc_n && !ce_n && (!lw_n || !uw_n)) |=> (state_q == ST_WRITE));

    // R5: advance steps the count and keeps the base
    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && state_q != ST_IDLE && !adv_n)
        |=> (cnt_q == CNT_W'($past(cnt_q) + 1) && $stable(base_q)));

    // R6: no advance holds the beat address
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && adv_n) |=> ($stable(cnt_q) && $stable(base_q)));

    // R9: deselecting strobe returns to idle
    a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ((!adsp_n || !adsc_n) && ce_n) |=> (state_q == ST_IDLE));

    // R11: idle without strobe stays idle
    a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && adsp_n && adsc_n) |=> (state_q == ST_IDLE));

    // R12: continue beat with a write enable low writes
    a_r12_continue_write: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && state_q != ST_IDLE && (!lw_n || !uw_n)) |=> (state_q == ST_WRITE));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [NUM_HALVES-1:0] wr_en,
    input  logic                  rd_en,
    output logic [WORD_W-1:0]     rdata_q
);

    localparam int DEPTH = 1 << ADDR_W;

    // One storage bank per independently writable half
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic [HALF_W-1:0] bank [DEPTH];
        logic [HALF_W-1:0] half_q;

        always_ff @(posedge clk) begin
            if (wr_en[h]) bank[acc_addr] <= wdata[h*HALF_W +: HALF_W];
            if (rd_en)    half_q         <= bank[acc_addr];
        end

        assign rdata_q[h*HALF_W +: HALF_W] = half_q;
    end

endmodule

// File: rtl/sbsram_out_drv.sv
module sbsram_out_drv
    import sbsram_pkg::*;
(
    input  burst_state_t      state_q,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] rdata_q,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_drive
);

    // Output enable is not registered: it gates the drive directly
    always_comb begin
        dq_drive = (state_q == ST_READ) && !oe_n;
        dq_out   = dq_drive ? rdata_q : '0;
    end

endmodule

// File: rtl/burst_cache_sram.sv
module burst_cache_sram
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                ce_n,
    input  logic                adsp_n,
    input  logic                adsc_n,
    input  logic                adv_n,
    input  logic                lw_n,
    input  logic                uw_n,
    input  logic                oe_n,
    input  logic [17:0]         dq_in,
    output logic [17:0]         dq_out,
    output logic                dq_drive
);

    logic [ADDR_W-1:0]     acc_addr;
    logic [NUM_HALVES-1:0] wr_en;
    logic                  rd_en;
    burst_state_t          state_q;
    logic [WORD_W-1:0]     rdata_q;

    sbsram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .ce_n     (ce_n),
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .adv_n    (adv_n),
        .lw_n     (lw_n),
        .uw_n     (uw_n),
        .acc_addr (acc_addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .state_q  (state_q)
    );

    sbsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .acc_addr (acc_addr),
        .wdata    (dq_in),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rdata_q  (rdata_q)
    );

    sbsram_out_drv u_out (
        .state_q  (state_q),
        .oe_n     (oe_n),
        .rdata_q  (rdata_q),
        .dq_out   (dq_out),
        .dq_drive (dq_drive)
    );

    // R2: the cycle after a processor strobe drives exactly when enabled
    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n) |=> (dq_drive == !oe_n));

    // R9: the cycle after a deselecting strobe does not drive
    a_r9_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((!adsp_n || !adsc_n) && ce_n) |=> !dq_drive);

endmodule

// File: tb/tb_burst_cache_sram.sv
`timescale 1ns/1ps
module tb_burst_cache_sram;

    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              ce_n, adsp_n, adsc_n, adv_n, lw_n, uw_n, oe_n;
    logic [17:0]       dq_in;
    logic [17:0]       dq_out;
    logic              dq_drive;

    int checks = 0;
    int fails  = 0;

    logic [17:0]       ref_mem [DEPTH];
    logic              m_act  = 1'b0;
    logic [ADDR_W-1:0] m_base = '0;
    logic [1:0]        m_cnt  = '0;
    logic              m_rd   = 1'b0;
    logic [17:0]       m_exp  = '0;

    always #2.5 clk = ~clk;

    burst_cache_sram #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .lw_n(lw_n), .uw_n(uw_n), .oe_n(oe_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] b, input logic [1:0] c);
        logic [ADDR_W-1:0] a;
        a      = b;
        a[1:0] = b[1:0] ^ c;
        return a;
    endfunction

    // One clock: inputs already set; predict, then check mid-cycle
    task automatic step(input string tag);
        logic wr, rd, we_any;
        logic [ADDR_W-1:0] a;
        @(posedge clk);
        wr = 1'b0; rd = 1'b0;
        we_any = !lw_n || !uw_n;
        if (!adsp_n || !adsc_n) begin
            if (ce_n) m_act = 1'b0;
            else begin
                m_act = 1'b1; m_base = addr; m_cnt = 2'd0;
                wr = adsp_n && we_any; rd = !wr;
            end
        end else if (m_act) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            wr = we_any; rd = !wr;
        end
        a = beat_addr(m_base, m_cnt);
        if (wr) begin
            if (!lw_n) ref_mem[a][8:0]  = dq_in[8:0];
            if (!uw_n) ref_mem[a][17:9] = dq_in[17:9];
        end
        m_rd  = rd;
        m_exp = ref_mem[a];
        @(negedge clk);
        chk({tag, " drive"}, 32'(dq_drive), 32'(m_rd && !oe_n));
        if (m_rd && !oe_n) chk({tag, " data"}, 32'(dq_out), 32'(m_exp));
    endtask

    task automatic quiet();
        adsp_n = 1; adsc_n = 1; adv_n = 1; lw_n = 1; uw_n = 1; ce_n = 0; oe_n = 0;
    endtask

    task automatic proc_read_burst(input logic [ADDR_W-1:0] a, input string tag);
        quiet(); adsp_n = 0; addr = a; step(tag);
        for (int k = 0; k < 4; k++) begin
            quiet(); adv_n = 0; addr = ~a; step(tag);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        quiet(); addr = '0; dq_in = '0; rst_n = 0;
        repeat (3) @(negedge clk);
        // R11: reset state, nothing driven
        chk("R11 reset drive", 32'(dq_drive), 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R1 R3 R12: fill the array with controller write bursts
        for (int blk = 0; blk < DEPTH / 4; blk++) begin
            quiet(); adsc_n = 0; lw_n = 0; uw_n = 0;
            addr = ADDR_W'(blk * 4 + (blk % 4)); dq_in = 18'($urandom);
            step("R3 fill start");
            for (int k = 0; k < 3; k++) begin
                quiet(); adv_n = 0; lw_n = 0; uw_n = 0; dq_in = 18'($urandom);
                step("R12 fill beat");
            end
        end

        // R5 R7: processor read bursts from every starting offset, wrapping
        for (int off = 0; off < 4; off++)
            proc_read_burst(ADDR_W'(40 + off), "R5 R7 R1 offset burst");

        // R2: processor strobe with write enables low reads, no write
        quiet(); adsp_n = 0; lw_n = 0; uw_n = 0; addr = 10'd77; dq_in = 18'h3ffff;
        step("R2 adsp ignores we");
        proc_read_burst(10'd77, "R2 readback");

        // R4: both strobes with write enables low -> read
        quiet(); adsp_n = 0; adsc_n = 0; lw_n = 0; addr = 10'd90; dq_in = 18'h15555;
        step("R4 priority");
        proc_read_burst(10'd90, "R4 readback");

        // R3: controller strobe read burst
        quiet(); adsc_n = 0; addr = 10'd123; step("R3 adsc read");
        quiet(); adv_n = 0; step("R3 adsc read beat");

        // R6: hold mid-burst
        quiet(); adsp_n = 0; addr = 10'd201; step("R6 start");
        quiet(); adv_n = 0; step("R6 beat");
        quiet(); step("R6 hold");
        quiet(); step("R6 hold again");
        quiet(); adv_n = 0; step("R6 resume");

        // R8: half writes, lower on strobe, upper on continue
        quiet(); adsc_n = 0; lw_n = 0; addr = 10'd302; dq_in = 18'h2a5a5;
        step("R8 lower half");
        quiet(); adv_n = 0; uw_n = 0; dq_in = 18'h1c3c3; step("R8 upper half");
        proc_read_burst(10'd302, "R8 readback");

        // R9: deselect with write enables low, no write, no drive
        quiet(); adsp_n = 0; addr = 10'd400; step("R9 pre");
        quiet(); adsc_n = 0; ce_n = 1; lw_n = 0; uw_n = 0; addr = 10'd400; dq_in = 18'h0f0f0;
        step("R9 deselect");
        // R11: idle cycles with write enables low write nothing
        quiet(); lw_n = 0; uw_n = 0; adv_n = 0; dq_in = 18'h33333; step("R11 idle we");
        quiet(); lw_n = 0; step("R11 idle we again");
        proc_read_burst(10'd400, "R9 R11 readback");

        // R10: asynchronous release of the drive in mid-cycle
        quiet(); adsp_n = 0; addr = 10'd500; step("R10 read");
        #1 oe_n = 1;
        #0.5 chk("R10 async release", 32'(dq_drive), 32'd0);
        quiet(); oe_n = 1; adv_n = 0; step("R10 oe high");

        // Random mix: R1 R2 R3 R5 R6 R8 R9 R12
        for (int i = 0; i < 3000; i++) begin
            quiet();
            adsp_n = ($urandom % 100) >= 12;
            adsc_n = ($urandom % 100) >= 15;
            ce_n   = ($urandom % 100) < 8;
            adv_n  = ($urandom % 100) >= 60;
            lw_n   = ($urandom % 100) >= 30;
            uw_n   = ($urandom % 100) >= 30;
            oe_n   = ($urandom % 100) < 10;
            addr   = ADDR_W'($urandom);
            dq_in  = 18'($urandom);
            step("R1 R5 R8 R12 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule